// File: doc/BRIEF.md
# Multiplexed Host-Port Access Sequencer

This block is the master-side engine for single read or write transfers to a peripheral with a 16-bit multiplexed host port, such as a DSP. A local requester presents an address, a direction flag and write data. The sequencer then runs one bus access through five phases that always come in the same order: address, data setup, strobe, hold and recovery. When recovery ends it pulses an acknowledge and returns any read data.

Each phase has a programmable length. A setting of N gives N+1 clocks. The address and setup settings are raised to at least 2, and the strobe setting to at least 1. The peripheral may assert a wait input at any time. Wait freezes the sequencer only while it is in the address or strobe phase. Once wait drops, the sequencer stays in the frozen phase for one more clock before it continues.

The requester raises `req_valid` and holds it until `req_ack`. A request is taken only while the sequencer is idle. Once taken, the address, data and direction are latched, so later changes on the request port have no effect on the running access.

Top module: `hps_sequencer`

## Requirements
- R1: During reset and after it, with no request, `bus_cs_n`, `bus_ds_n` and `bus_rw_n` are high, and `bus_oe` and `req_ack` are low.
- R2: `bus_cs_n` falls and `bus_sel` carries the latched address in the same cycle. `bus_ds_n` falls max(cfg_addr,2)+1+max(cfg_setup,2)+1 cycles after `bus_cs_n` falls, when no wait occurs.
- R3: `bus_ds_n` stays low for max(cfg_strobe,1)+1 cycles when no wait occurs, and never for fewer than two. It is low only while `bus_cs_n` is low.
- R4: `bus_cs_n` rises cfg_hold+1 cycles after `bus_ds_n` rises.
- R5: `req_ack` is high for exactly one cycle per access. That cycle is the last recovery cycle, cfg_recov cycles after the cycle in which `bus_cs_n` rises.
- R6: A wait raised in the first address cycle and held for W cycles lengthens the address phase by W+1 cycles. The sequencer stays in the address phase for at least one clock after wait falls.
- R7: A wait raised in the first strobe cycle and held for W cycles lengthens the strobe phase by W+1 cycles.
- R8: A wait that is asserted and released entirely within the setup phase does not change any phase length.
- R9: On a read, `ack_rdata` during the acknowledge cycle equals the value that `bus_rdata` had in the last strobe cycle. `bus_oe` stays low for the whole read.
- R10: On a write, `bus_rw_n` is low for every cycle that `bus_cs_n` is low. `bus_oe` is high over exactly the setup, strobe and hold phases, and `bus_dout` equals the write data in those cycles.
- R11: A request is taken only from idle. Changes to `req_addr`, `req_wdata` or `req_write` after acceptance do not change `bus_sel`, `bus_dout` or `bus_rw_n` during that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request, held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Control-select value for the access |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| ack_rdata | output | 16 | Read data, valid with `req_ack` on a read |
| cfg_addr | input | 4 | Address phase setting |
| cfg_setup | input | 4 | Setup phase setting |
| cfg_strobe | input | 4 | Strobe phase setting |
| cfg_hold | input | 4 | Hold phase setting |
| cfg_recov | input | 4 | Recovery phase setting |
| bus_wait | input | 1 | Peripheral wait, active high |
| bus_rdata | input | 16 | Data from the peripheral |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rw_n | output | 1 | Direction, low for a write |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_sel | output | 2 | Control-select lines |
| bus_dout | output | 16 | Data toward the peripheral |
| bus_oe | output | 1 | Output enable for `bus_dout` |

## Verification
The bus pins are decoded from registered phase state, so each one moves in the cycle after the clock edge that changes the phase. The bench samples them at the falling clock edge and records the cycle index of every edge of chip select and strobe. It then compares the differences between those indices with the phase lengths it computes from the settings, plus W+1 for each wait pulse. The acknowledge is due cfg_recov cycles after chip select rises. Read data is due in that same acknowledge cycle and must match the bus value that the bench saw in the last strobe-low cycle.

// File: rtl/hps_pkg.sv
package hps_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ADDR   = 3'd1,
    PH_SETUP  = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4,
    PH_RECOV  = 3'd5
  } phase_e;

  // Programmed setting raised to its floor; the phase then lasts this value + 1 clocks.
  function automatic int unsigned clamp_span(int unsigned prog, int unsigned floor_v);
    return (prog < floor_v) ? floor_v : prog;
  endfunction

  // Phases in which the peripheral wait may freeze the sequencer.
  function automatic logic wait_sensitive(phase_e ph);
    return (ph == PH_ADDR) || (ph == PH_STROBE);
  endfunction

  // Phases with chip select active.
  function automatic logic bus_active(phase_e ph);
    return (ph == PH_ADDR) || (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
  endfunction

  // Phases in which write data is driven.
  function automatic logic drive_window(phase_e ph);
    return (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
  endfunction

endpackage

// File: rtl/hps_timing.sv
module hps_timing
  import hps_pkg::*;
#(
  parameter int unsigned PAR_W      = 4,
  parameter int unsigned MIN_ADDR   = 2,
  parameter int unsigned MIN_SETUP  = 2,
  parameter int unsigned MIN_STROBE = 1
) (
  input  phase_e             nxt_phase,
  input  logic [PAR_W-1:0]   cfg_addr,
  input  logic [PAR_W-1:0]   cfg_setup,
  input  logic [PAR_W-1:0]   cfg_strobe,
  input  logic [PAR_W-1:0]   cfg_hold,
  input  logic [PAR_W-1:0]   cfg_recov,
  output logic [PAR_W-1:0]   load_val
);

  logic [PAR_W-1:0] span_addr;
  logic [PAR_W-1:0] span_setup;
  logic [PAR_W-1:0] span_strobe;

  assign span_addr   = PAR_W'(clamp_span(32'(cfg_addr),   MIN_ADDR));
  assign span_setup  = PAR_W'(clamp_span(32'(cfg_setup),  MIN_SETUP));
  assign span_strobe = PAR_W'(clamp_span(32'(cfg_strobe), MIN_STROBE));

  always_comb begin
    unique case (nxt_phase)
      PH_ADDR:   load_val = span_addr;
      PH_SETUP:  load_val = span_setup;
      PH_STROBE: load_val = span_strobe;
      PH_HOLD:   load_val = cfg_hold;
      PH_RECOV:  load_val = cfg_recov;
      default:   load_val = '0;
    endcase
  end

  initial begin
    assert ((MIN_ADDR < (1 << PAR_W)) && (MIN_SETUP < (1 << PAR_W)) && (MIN_STROBE < (1 << PAR_W)))
      else $error("phase floors exceed setting width");
  end

endmodule

// File: rtl/hps_ctrl.sv
module hps_ctrl
  import hps_pkg::*;
#(
  parameter int unsigned PAR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             bus_wait,
  input  logic [PAR_W-1:0] load_val,
  output phase_e           phase,
  output phase_e           nxt_phase,
  output logic             start_evt,
  output logic             ack_evt,
  output logic             cap_evt
);

  logic [PAR_W-1:0] cnt;
  logic             wait_q;
  logic             stall;
  logic             last_cyc;
  logic             advance;

  assign stall     = wait_sensitive(phase) && (bus_wait || wait_q);
  assign last_cyc  = (cnt == '0);
  assign advance   = (phase != PH_IDLE) && last_cyc && !stall;
  assign start_evt = (phase == PH_IDLE) && req_valid;
  assign ack_evt   = (phase == PH_RECOV) && advance;
  assign cap_evt   = (phase == PH_STROBE) && advance;

  always_comb begin
    nxt_phase = phase;
    unique case (phase)
      PH_IDLE:   if (start_evt) nxt_phase = PH_ADDR;
      PH_ADDR:   if (advance)   nxt_phase = PH_SETUP;
      PH_SETUP:  if (advance)   nxt_phase = PH_STROBE;
      PH_STROBE: if (advance)   nxt_phase = PH_HOLD;
      PH_HOLD:   if (advance)   nxt_phase = PH_RECOV;
      PH_RECOV:  if (advance)   nxt_phase = PH_IDLE;
      default:                  nxt_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      wait_q <= 1'b0;
    end else begin
      wait_q <= bus_wait;
      if (start_evt || advance) begin
        phase <= nxt_phase;
        cnt   <= load_val;
      end else if (!stall && !last_cyc) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R6
  addr_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ADDR && bus_wait) |=> (phase == PH_ADDR));

  // R7
  strobe_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STROBE && bus_wait) |=> (phase == PH_STROBE));

  // R6
  wait_release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_sensitive(phase) && wait_q && !bus_wait) |=> (phase == $past(phase)));

  // R11
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ADDR && $past(phase) != PH_ADDR) |-> ($past(phase) == PH_IDLE));

endmodule

// File: rtl/hps_datapath.sv
module hps_datapath
  import hps_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              start_evt,
  input  logic              cap_evt,
  input  logic              req_write,
  input  logic [SEL_W-1:0]  req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] ack_rdata,
  output logic              bus_cs_n,
  output logic              bus_rw_n,
  output logic              bus_ds_n,
  output logic [SEL_W-1:0]  bus_sel,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe
);

  logic              wr_q;
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              active;
  logic              drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      sel_q   <= '0;
      wdata_q <= '0;
    end else if (start_evt) begin
      wr_q    <= req_write;
      sel_q   <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (cap_evt) rdata_q <= bus_rdata;
  end

  assign active    = bus_active(phase);
  assign drive     = wr_q && drive_window(phase);
  assign bus_cs_n  = !active;
  assign bus_ds_n  = (phase != PH_STROBE);
  assign bus_rw_n  = !(active && wr_q);
  assign bus_sel   = active ? sel_q : '0;
  assign bus_oe    = drive;
  assign bus_dout  = drive ? wdata_q : '0;
  assign ack_rdata = rdata_q;

  // R11
  sel_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && !$past(bus_cs_n)) |-> (bus_sel == $past(bus_sel)));

  // R10
  dout_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe)) |-> (bus_dout == $past(bus_dout)));

endmodule

// File: rtl/hps_sequencer.sv
module hps_sequencer
  import hps_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SEL_W      = 2,
  parameter int unsigned PAR_W      = 4,
  parameter int unsigned MIN_ADDR   = 2,
  parameter int unsigned MIN_SETUP  = 2,
  parameter int unsigned MIN_STROBE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [SEL_W-1:0]  req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] ack_rdata,
  input  logic [PAR_W-1:0]  cfg_addr,
  input  logic [PAR_W-1:0]  cfg_setup,
  input  logic [PAR_W-1:0]  cfg_strobe,
  input  logic [PAR_W-1:0]  cfg_hold,
  input  logic [PAR_W-1:0]  cfg_recov,
  input  logic              bus_wait,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_cs_n,
  output logic              bus_rw_n,
  output logic              bus_ds_n,
  output logic [SEL_W-1:0]  bus_sel,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe
);

  phase_e           phase;
  phase_e           nxt_phase;
  logic [PAR_W-1:0] load_val;
  logic             start_evt;
  logic             ack_evt;
  logic             cap_evt;

  hps_timing #(
    .PAR_W(PAR_W), .MIN_ADDR(MIN_ADDR), .MIN_SETUP(MIN_SETUP), .MIN_STROBE(MIN_STROBE)
  ) i_timing (
    .nxt_phase (nxt_phase),
    .cfg_addr  (cfg_addr),
    .cfg_setup (cfg_setup),
    .cfg_strobe(cfg_strobe),
    .cfg_hold  (cfg_hold),
    .cfg_recov (cfg_recov),
    .load_val  (load_val)
  );

  hps_ctrl #(.PAR_W(PAR_W)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .bus_wait (bus_wait),
    .load_val (load_val),
    .phase    (phase),
    .nxt_phase(nxt_phase),
    .start_evt(start_evt),
    .ack_evt  (ack_evt),
    .cap_evt  (cap_evt)
  );

  hps_datapath #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .start_evt(start_evt),
    .cap_evt  (cap_evt),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .bus_rdata(bus_rdata),
    .ack_rdata(ack_rdata),
    .bus_cs_n (bus_cs_n),
    .bus_rw_n (bus_rw_n),
    .bus_ds_n (bus_ds_n),
    .bus_sel  (bus_sel),
    .bus_dout (bus_dout),
    .bus_oe   (bus_oe)
  );

  assign req_ack = ack_evt;

  // R5
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  // R5
  ack_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> bus_cs_n);

  // R3
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ds_n |-> !bus_cs_n);

  // R3
  strobe_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ds_n) |-> (!$past(bus_ds_n) && !$past(bus_ds_n, 2)));

  // R10
  oe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!bus_cs_n && !bus_rw_n));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |-> (bus_ds_n && bus_rw_n && !bus_oe));

endmodule

// File: tb/test_hps_sequencer.sv
module test_hps_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ack;
  logic [15:0] ack_rdata;
  logic [3:0]  cfg_addr = '0, cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0, cfg_recov = '0;
  logic        bus_wait = 1'b0;
  logic [15:0] bus_rdata;
  logic        bus_cs_n, bus_rw_n, bus_ds_n, bus_oe;
  logic [1:0]  bus_sel;
  logic [15:0] bus_dout;

  always #4 clk = ~clk;

  hps_sequencer i_hps_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack), .ack_rdata(ack_rdata),
    .cfg_addr(cfg_addr), .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe),
    .cfg_hold(cfg_hold), .cfg_recov(cfg_recov), .bus_wait(bus_wait), .bus_rdata(bus_rdata),
    .bus_cs_n(bus_cs_n), .bus_rw_n(bus_rw_n), .bus_ds_n(bus_ds_n), .bus_sel(bus_sel),
    .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  int checks = 0;
  int errors = 0;

  logic [15:0] rd_pat = 16'h2c41;
  always @(posedge clk) rd_pat <= rd_pat + 16'h1357;
  assign bus_rdata = rd_pat;

  // monitor state
  int cyc = 0;
  int t_csf, t_dsf, t_dsr, t_csr, t_ack;
  int oe_cnt, oe_early, bad_sel, bad_rw, bad_dout, bad_idle, ack_cnt;
  logic [15:0] last_rd, ack_data;
  logic cs_q = 1'b1, ds_q = 1'b1;
  logic        exp_wr;
  logic [1:0]  exp_sel;
  logic [15:0] exp_wd;
  int addr_len_nom;
  int wmode = 0;   // 0 none, 1 address, 2 strobe, 3 setup
  int wlen = 0;
  int wcnt = 0;
  bit scramble = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (wcnt > 0) begin
      wcnt--;
      if (wcnt == 0) bus_wait = 1'b0;
    end
    if (!bus_cs_n && cs_q) begin
      t_csf = cyc; oe_cnt = 0; oe_early = 0; bad_sel = 0; bad_rw = 0; bad_dout = 0;
      if (wmode == 1) begin bus_wait = 1'b1; wcnt = wlen; end
    end
    if (wmode == 3 && !bus_cs_n && cyc == t_csf + addr_len_nom) begin
      bus_wait = 1'b1; wcnt = wlen;
    end
    if (!bus_ds_n && ds_q) begin
      t_dsf = cyc;
      if (wmode == 2) begin bus_wait = 1'b1; wcnt = wlen; end
      if (scramble) begin
        req_addr = ~exp_sel; req_wdata = ~exp_wd; req_write = ~exp_wr;
      end
    end
    if (bus_ds_n && !ds_q) t_dsr = cyc;
    if (bus_cs_n && !cs_q) t_csr = cyc;
    if (!bus_ds_n) last_rd = bus_rdata;
    if (!bus_cs_n) begin
      if (bus_sel != exp_sel) bad_sel++;
      if (bus_rw_n != !exp_wr) bad_rw++;
      if (bus_oe) begin
        oe_cnt++;
        if (bus_dout != exp_wd) bad_dout++;
        if (cyc < t_csf + addr_len_nom) oe_early++;
      end
    end else if (bus_oe || !bus_rw_n || !bus_ds_n) begin
      bad_idle++;
    end
    if (req_ack) begin ack_cnt++; t_ack = cyc; ack_data = ack_rdata; end
    cs_q = bus_cs_n; ds_q = bus_ds_n;
  end

  function automatic int span(int prog, int fl);
    return ((prog < fl) ? fl : prog) + 1;
  endfunction

  task automatic run_access(input bit wr, input logic [1:0] sel, input logic [15:0] wd,
                            input int a, input int s, input int st, input int h, input int r,
                            input int mode, input int wl, input bit scr);
    int la, ls, lt, lh, lr, guard;
    bit seen;
    @(negedge clk); #2;
    cfg_addr = 4'(a); cfg_setup = 4'(s); cfg_strobe = 4'(st); cfg_hold = 4'(h); cfg_recov = 4'(r);
    exp_wr = wr; exp_sel = sel; exp_wd = wd;
    req_write = wr; req_addr = sel; req_wdata = wd;
    addr_len_nom = span(a, 2);
    wmode = mode; wlen = wl; scramble = scr; ack_cnt = 0; bad_idle = 0;
    req_valid = 1'b1;
    seen = 0; guard = 0;
    while (!seen && guard < 400) begin
      @(negedge clk); #2;
      guard++;
      if (ack_cnt != 0) seen = 1;
    end
    req_valid = 1'b0; wmode = 0; scramble = 0;
    @(negedge clk); #2;
    check(seen, "R5 access completed (watchdog)", guard, 0);
    if (!seen) return;
    la = span(a, 2) + ((mode == 1) ? wl + 1 : 0);
    ls = span(s, 2);
    lt = span(st, 1) + ((mode == 2) ? wl + 1 : 0);
    lh = h + 1;
    lr = r + 1;
    check(t_dsf - t_csf == la + ls, (mode == 1) ? "R6 address+setup span" :
          (mode == 3) ? "R8 address+setup span" : "R2 address+setup span",
          t_dsf - t_csf, la + ls);
    check(t_dsr - t_dsf == lt, (mode == 2) ? "R7 strobe width" : "R3 strobe width",
          t_dsr - t_dsf, lt);
    check(t_csr - t_dsr == lh, "R4 hold length", t_csr - t_dsr, lh);
    check(t_ack - t_csr == lr - 1, "R5 ack position", t_ack - t_csr, lr - 1);
    check(ack_cnt == 1, "R5 ack count", ack_cnt, 1);
    check(bad_sel == 0, scr ? "R11 select held" : "R2 select valid", bad_sel, 0);
    check(bad_idle == 0, "R1 quiet outside access", bad_idle, 0);
    if (wr) begin
      check(bad_rw == 0, "R10 direction low", bad_rw, 0);
      check(oe_cnt == ls + lt + lh, "R10 enable window", oe_cnt, ls + lt + lh);
      check(oe_early == 0, "R10 enable not in address", oe_early, 0);
      check(bad_dout == 0, scr ? "R11 write data held" : "R10 write data", bad_dout, 0);
    end else begin
      check(bad_rw == 0, scr ? "R11 direction held" : "R9 direction high", bad_rw, 0);
      check(oe_cnt == 0, "R9 no enable on read", oe_cnt, 0);
      check(ack_data == last_rd, "R9 read capture", int'(ack_data), int'(last_rd));
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    check(bus_cs_n && bus_ds_n && bus_rw_n && !bus_oe && !req_ack, "R1 reset outputs",
          {bus_cs_n, bus_ds_n, bus_rw_n, bus_oe, req_ack}, 5'b11100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(bus_cs_n && bus_ds_n && bus_rw_n && !bus_oe && !req_ack, "R1 idle outputs",
          {bus_cs_n, bus_ds_n, bus_rw_n, bus_oe, req_ack}, 5'b11100);

    idx = 0;
    for (int a = 0; a < 4; a++)
      for (int s = 0; s < 4; s++)
        for (int st = 0; st < 3; st++)
          for (int h = 0; h < 3; h++)
            for (int r = 0; r < 3; r++) begin
              run_access(idx[0], 2'(idx >> 1), 16'(idx * 16'h0b3d + 16'h5a00), a, s, st, h, r, 0, 0, 0);
              idx++;
            end

    for (int w = 1; w <= 5; w += 2) begin
      run_access(1'b1, 2'd2, 16'h1234 + 16'(w), 2, 2, 1, 1, 1, 1, w, 0);
      run_access(1'b0, 2'd1, 16'h0,             2, 2, 1, 1, 1, 1, w, 0);
      run_access(1'b1, 2'd3, 16'hbeef,          3, 2, 2, 0, 0, 2, w, 0);
      run_access(1'b0, 2'd0, 16'h0,             2, 2, 1, 1, 2, 2, w, 0);
    end
    run_access(1'b1, 2'd1, 16'h7777, 2, 2, 1, 1, 1, 3, 1, 0);
    run_access(1'b0, 2'd2, 16'h0,    2, 3, 1, 1, 1, 3, 2, 0);

    run_access(1'b1, 2'd2, 16'hc3a5, 2, 2, 1, 1, 1, 0, 0, 1);
    run_access(1'b0, 2'd1, 16'h0f0f, 3, 2, 2, 2, 1, 0, 0, 1);

    repeat (4) @(negedge clk);
    check(bus_cs_n && !req_ack, "R1 idle after traffic", {bus_cs_n, req_ack}, 2'b10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule